// File: doc/BRIEF.md
# Processor Sleep Clock Gate

This block produces the gated clocks for two processor cores, a main core and a coprocessor, from one free-running clock. Each core can put itself to sleep. The core raises a wait-for-interrupt request pulse and keeps its clock until its instruction in progress reports completion. On that completion strobe the core's clock stops. Any enabled interrupt, on either the fast or the normal line, starts the clock again. An asynchronous reset also starts it again.

The main core's gate comes out of reset running. The coprocessor's gate comes out of reset off. It stays off until the main side writes 1 to the coprocessor enable bit. Each core has a status bit that shows whether its clock is running now. The input clock runs on for every other bus master, and neither core's sleep state affects the other.

Top module: `sleep_clk_gate`

## Requirements
- R1: While reset is held and after it is released, core 0 (main) reports running (`run_o[0]`=1), and its gated clock follows `clk_i`.
- R2: After reset, core 1 (coprocessor) reports stopped and its gated clock stays low. A clock edge with `co_en_we_i`=1 loads `co_en_d_i` into the enable bit. Core 1 runs only while that bit is 1 and it is not asleep. The bit does not affect core 0.
- R3: A `wfi_i` pulse on a running core, with no interrupt in the same cycle, arms a pending sleep. The clock keeps running while the sleep is pending. A `retire_i` in the same cycle as the request does not count.
- R4: On the first `retire_i` edge after the request, the core goes to sleep, and `run_o` is 0 from that edge on.
- R5: `irq_i` or `fiq_i` high at an edge puts the core back in the running state from that edge on, whether it was sleeping or had a sleep pending. A pending sleep is cancelled.
- R6: An interrupt in the same cycle as `wfi_i` cancels the request, and the clock keeps running.
- R7: While a core sleeps, `wfi_i` and `retire_i` have no effect, and the core stays stopped until an interrupt or a reset.
- R8: Asserting `rst_ni` low ends sleep at once, with no clock edge needed.
- R9: The gated clock is free of glitches. It is low whenever `clk_i` is low. In the high phase that follows an edge, it equals the run status from before that edge, so a change in `run_o` reaches the clock one cycle later.
- R10: The two cores are independent. Stimulus on one core's inputs never changes the other core's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock, also used by other bus masters |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_i | input | NCORE | Wait-for-interrupt request pulse per core (bit 0 main, bit 1 coprocessor) |
| retire_i | input | NCORE | Instruction-complete strobe per core |
| irq_i | input | NCORE | Enabled normal interrupt per core |
| fiq_i | input | NCORE | Enabled fast interrupt per core |
| co_en_we_i | input | 1 | Write strobe for the coprocessor enable bit |
| co_en_d_i | input | 1 | Value written to the coprocessor enable bit |
| gclk_o | output | NCORE | Gated core clocks |
| run_o | output | NCORE | Per-core status: clock currently running |

## Verification
A wrong sleep state shows on `run_o` at the edge right after the faulty transition, and on `gclk_o` in the high phase one cycle later. The bench compares both outputs with a behavioural model in every phase, so a missed or early stop is caught within one cycle. A missed cancel by an interrupt, or a leak between the two cores, is also caught within one cycle. A glitch or a stuck latch shows as `gclk_o` high in a low phase, or as a high phase that does not match the model.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PEND  = 2'd1,
    ST_SLEEP = 2'd2
  } sleep_st_e;
endpackage

// File: rtl/clk_gate_latch.sv
module clk_gate_latch (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // transparent while clock low, so enable is frozen across the high phase
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wfi_i,
  input  logic retire_i,
  input  logic wake_i,
  output logic awake_o
);
  sleep_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wake_i)                          st_d = ST_RUN;
    else if (st_q == ST_PEND && retire_i) st_d = ST_SLEEP;
    else if (st_q == ST_RUN && wfi_i)     st_d = ST_PEND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign awake_o = (st_q != ST_SLEEP);

  a_r3_pend_from_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && wfi_i && !wake_i) |=> (st_q == ST_PEND));

  a_r4_stop_on_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PEND && retire_i && !wake_i) |=> !awake_o);

  a_r5_wake_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (st_q == ST_RUN));

  a_r7_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && !wake_i) |=> (st_q == ST_SLEEP));
endmodule

// File: rtl/sleep_clk_gate.sv
module sleep_clk_gate #(
  parameter int NCORE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCORE-1:0] wfi_i,
  input  logic [NCORE-1:0] retire_i,
  input  logic [NCORE-1:0] irq_i,
  input  logic [NCORE-1:0] fiq_i,
  input  logic             co_en_we_i,
  input  logic             co_en_d_i,
  output logic [NCORE-1:0] gclk_o,
  output logic [NCORE-1:0] run_o
);
  localparam int CO_IDX = NCORE - 1;

  logic co_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         co_en_q <= 1'b0;
    else if (co_en_we_i) co_en_q <= co_en_d_i;
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic awake;
    logic en;

    sleep_fsm u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wfi_i   (wfi_i[c]),
      .retire_i(retire_i[c]),
      .wake_i  (irq_i[c] | fiq_i[c]),
      .awake_o (awake)
    );

    if (c == CO_IDX) begin : g_sw_enable
      assign en = awake & co_en_q;
    end else begin : g_always_enable
      assign en = awake;
    end

    clk_gate_latch u_cg (
      .clk_i (clk_i),
      .en_i  (en),
      .gclk_o(gclk_o[c])
    );

    assign run_o[c] = en;
  end

  a_r2_co_off_until_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (co_en_we_i && !co_en_d_i) |=> !run_o[CO_IDX]);

  a_r1_main_on_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> run_o[0]);
endmodule

// File: tb/sleep_clk_gate_test.sv
module sleep_clk_gate_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] wfi = '0, ret = '0, irq = '0, fiq = '0;
  logic we = 1'b0, wd = 1'b0;
  logic [1:0] gclk, run;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_st [2];
  bit m_en [2];
  bit m_run_prev [2];

  always #10 clk = ~clk;

  sleep_clk_gate uut (
    .clk_i(clk), .rst_ni(rst_ni), .wfi_i(wfi), .retire_i(ret),
    .irq_i(irq), .fiq_i(fiq), .co_en_we_i(we), .co_en_d_i(wd),
    .gclk_o(gclk), .run_o(run)
  );

  function automatic bit m_run(int c);
    return m_en[c] && m_st[c] != 2;
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st[0] = 0; m_st[1] = 0; m_en[0] = 1; m_en[1] = 0;
  endtask

  // inputs driven at negedge, model steps at posedge, outputs checked mid-phase
  task automatic step(logic [1:0] w, logic [1:0] r, logic [1:0] i, logic [1:0] f,
                      logic e_we, logic e_d, string tag);
    @(negedge clk);
    for (int c = 0; c < 2; c++) chk(tag, gclk[c], 1'b0, "gclk low phase (R9)");
    wfi = w; ret = r; irq = i; fiq = f; we = e_we; wd = e_d;
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      m_run_prev[c] = m_run(c);
      if (i[c] | f[c])                 m_st[c] = 0;
      else if (m_st[c] == 1 && r[c])   m_st[c] = 2;
      else if (m_st[c] == 0 && w[c])   m_st[c] = 1;
    end
    if (e_we) m_en[1] = e_d;
    #5;
    for (int c = 0; c < 2; c++) begin
      chk(tag, run[c], m_run(c), $sformatf("run_o[%0d]", c));
      chk(tag, gclk[c], m_run_prev[c], $sformatf("gclk_o[%0d] high phase (R9)", c));
    end
    #1;
    wfi = '0; ret = '0; irq = '0; fiq = '0; we = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    m_run_prev[0] = 1; m_run_prev[1] = 0;
    #25;
    chk("R1", run[0], 1'b1, "main run in reset");
    chk("R2", run[1], 1'b0, "co run in reset");
    @(negedge clk); rst_ni = 1'b1;
    step('0, '0, '0, '0, 0, 0, "R1");
    step('0, '0, '0, '0, 0, 0, "R1");
    // R2: co stays off, then enabled
    step('0, '0, 2'b10, '0, 0, 0, "R2");
    step('0, '0, '0, '0, 1, 1, "R2");
    step('0, '0, '0, '0, 0, 0, "R2");
    // R3/R4 main: request, retire in same cycle ignored, then retire
    step(2'b01, 2'b01, '0, '0, 0, 0, "R3");
    step('0, '0, '0, '0, 0, 0, "R3");
    step('0, 2'b01, '0, '0, 0, 0, "R4");
    step('0, '0, '0, '0, 0, 0, "R4");
    // R7: ignored while asleep
    step(2'b01, 2'b01, '0, '0, 0, 0, "R7");
    step('0, 2'b01, '0, '0, 0, 0, "R7");
    // R5: irq wakes
    step('0, '0, 2'b01, '0, 0, 0, "R5");
    step('0, '0, '0, '0, 0, 0, "R5");
    // R5: fiq cancels pending sleep
    step(2'b01, '0, '0, '0, 0, 0, "R5");
    step('0, 2'b01, '0, 2'b01, 0, 0, "R5");
    step('0, 2'b01, '0, '0, 0, 0, "R5");
    // R6: interrupt with request cancels
    step(2'b01, '0, 2'b01, '0, 0, 0, "R6");
    step('0, 2'b01, '0, '0, 0, 0, "R6");
    // R10: co sleeps, main unaffected
    step(2'b10, '0, '0, '0, 0, 0, "R10");
    step('0, 2'b10, '0, '0, 0, 0, "R10");
    step('0, '0, '0, '0, 0, 0, "R10");
    step('0, '0, '0, 2'b10, 0, 0, "R10");
    // R2: disable co, main unaffected
    step('0, '0, '0, '0, 1, 0, "R2");
    step('0, '0, 2'b10, '0, 0, 0, "R2");
    step('0, '0, '0, '0, 1, 1, "R2");
    // R8: reset ends main sleep
    step(2'b01, '0, '0, '0, 0, 0, "R8");
    step('0, 2'b01, '0, '0, 0, 0, "R8");
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    model_reset();
    chk("R8", run[0], 1'b1, "main run after async reset");
    chk("R8", run[1], 1'b0, "co run after async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    m_run_prev[0] = 1; m_run_prev[1] = 0;
    step('0, '0, '0, '0, 0, 0, "R8");
    step('0, '0, '0, '0, 0, 0, "R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule